// File: doc/BRIEF.md
# Memory Access Security Filter with Transfer Gating

This block sits in front of a protected memory and checks every incoming request against a per-block security table. The controlled window starts at a fixed base address. The window is split into equal blocks of 2^(cfg+5) bytes, where `cfg` is a runtime input. Each block owns one bit in a table of 32-bit words, and a set bit opens that block to non-secure masters. A permitted request is handed downstream. A non-secure request that hits a block marked secure is stopped. The requester then gets either a bus error or a quiet completion, which reads as zero and drops the write. The stop also latches a fault that can raise an interrupt.

The table is held inside the block as a synchronous RAM. A separate configuration agent fills it through a simple word write port. Software can also ask the block to gate traffic. Once the filter is idle, it acknowledges the request. While gating is requested, new requests are either stalled (ready held low) or answered with a bus error, depending on a select input. Each control bit arrives as its own input port.

Top module: `mpc_access_filter`

## Requirements
- R1: The block number is (addr − base) >> (cfg + 5). Its table entry is bit (number % 32) of word (number / 32), and a 1 in that entry admits non-secure requests.
- R2: A non-secure request to a block whose entry is 0 never reaches the downstream side. Two cycles after acceptance, `resp_valid` pulses for one cycle. During that pulse, `resp_err` equals `fault_err_sel`: 1 means bus error, 0 means completion with zero read data and the write dropped.
- R3: A secure request (`up_nonsec`=0) is always forwarded, whatever its entry. A request below the base, or at or beyond base + 32·LUT_WORDS blocks, is forwarded with no fault.
- R4: A forwarded request raises `dn_valid` two cycles after acceptance. `dn_addr`, `dn_write` and `dn_nonsec` carry the accepted values and stay unchanged until a cycle with `dn_ready` high ends the transfer.
- R5: Only one request is in flight at a time. `up_ready` is high only when the filter is idle and no stall is requested (`gate_req`=1 with `gate_err_sel`=0 is a stall request).
- R6: `gate_ack` rises in the cycle after a clock edge at which `gate_req` was high and the filter was idle. It falls in the cycle after the edge at which `gate_req` is seen low. It is never high while `dn_valid` is high.
- R7: A request accepted while `gate_req`=1 and `gate_err_sel`=1 gets a `resp_valid` pulse with `resp_err`=1, is not forwarded, and sets no fault.
- R8: A security stop sets `irq_stat`, and `irq_clr` clears it. If both happen in the same cycle, the set wins. `irq` = `irq_stat` AND `irq_en`.
- R9: `gate_present` reads 1 when the gating parameter is enabled.
- R10: A table word write affects every request accepted after the write edge. A lookup issued at the same edge as the write still sees the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_cfg | input | CFG_W | Block size select, size = 2^(blk_cfg+5) bytes |
| lut_we | input | 1 | Table word write strobe |
| lut_waddr | input | WORD_AW | Table word index to write |
| lut_wdata | input | 32 | Table word data, 1 = non-secure allowed |
| up_valid | input | 1 | Request valid |
| up_ready | output | 1 | Request accepted when high with up_valid |
| up_addr | input | ADDR_W | Request address |
| up_write | input | 1 | 1 = write request |
| up_nonsec | input | 1 | 1 = non-secure request |
| dn_valid | output | 1 | Forwarded request valid |
| dn_ready | input | 1 | Downstream accepts the forwarded request |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_write | output | 1 | Forwarded write flag |
| dn_nonsec | output | 1 | Forwarded security attribute |
| resp_valid | output | 1 | One-cycle local completion for a stopped request |
| resp_err | output | 1 | 1 = bus error, 0 = read-zero / write-dropped completion |
| fault_err_sel | input | 1 | Response type for security stops |
| gate_req | input | 1 | Gating request |
| gate_err_sel | input | 1 | Under gating: 1 = error new requests, 0 = stall them |
| gate_ack | output | 1 | Gating acknowledged |
| gate_present | output | 1 | Gating feature built in |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clear the fault status |
| irq_stat | output | 1 | Fault status |
| irq | output | 1 | Fault interrupt |

## Verification
Requests are aimed at blocks whose bits are set and clear, at the last bit of one table word and the first bit of the next, and just outside the window on both sides. These cases separate correct block-to-word-and-bit mapping from off-by-one or wrong-word mistakes. The same blocks are revisited with a larger block size and after a table rewrite, which shows that the shift amount and the table contents are both used live. Secure requests to secure blocks, stops under both response selects, and the gating cases are kept apart from each other. Those gating cases are a stall, an error mode, and an acknowledge held off by a downstream transfer kept waiting. This split shows which outcome each control input steers, and it shows that gating errors leave the fault status untouched.

// File: rtl/mpc_flt_pkg.sv
package mpc_flt_pkg;
  localparam int unsigned LUT_WORD_BITS  = 32;
  localparam int unsigned BLK_SHIFT_BASE = 5;

  typedef enum logic [1:0] {
    FLT_IDLE   = 2'd0,
    FLT_LOOKUP = 2'd1,
    FLT_HOLD   = 2'd2
  } flt_state_e;
endpackage

// File: rtl/mpc_lut_ram.sv
module mpc_lut_ram #(
  parameter int unsigned WORDS   = 8,
  parameter int unsigned AW      = 3,
  parameter int unsigned WIDTH   = 32
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [WORDS];

  // read-first single clock RAM: a same-edge write is not seen by the read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mpc_blk_locate.sv
module mpc_blk_locate #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CFG_W      = 4,
  parameter int unsigned NUM_BLOCKS = 256,
  parameter int unsigned WORD_AW    = 3,
  parameter int unsigned BIT_W      = 5,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CFG_W-1:0]   cfg,
  output logic               in_range,
  output logic [WORD_AW-1:0] word_idx,
  output logic [BIT_W-1:0]   bit_idx
);
  import mpc_flt_pkg::*;

  localparam int unsigned SH_W = $clog2(ADDR_W + 1) + 1;

  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] idx;
  logic [SH_W-1:0]   shamt;

  always_comb begin
    offs     = addr - BASE;
    shamt    = SH_W'(cfg) + SH_W'(BLK_SHIFT_BASE);
    idx      = offs >> shamt;
    in_range = (addr >= BASE) && (idx < ADDR_W'(NUM_BLOCKS));
    word_idx = WORD_AW'(idx >> BIT_W);
    bit_idx  = BIT_W'(idx);
  end
endmodule

// File: rtl/mpc_gate_ctl.sv
module mpc_gate_ctl #(
  parameter bit GATING_EN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_req,
  input  logic gate_err_sel,
  input  logic idle,
  input  logic dn_busy,
  output logic gate_on,
  output logic stall,
  output logic gate_ack
);
  generate
    if (GATING_EN) begin : g_gate
      logic ack_q;
      always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= gate_req && idle;
      end
      assign gate_on  = gate_req;
      assign stall    = gate_req && !gate_err_sel;
      assign gate_ack = ack_q;

      // R6: acknowledge drops the cycle after the request is seen low
      a_r6_ack_release: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_req) |=> !gate_ack);
      // R6: quiescence, nothing is handed downstream while acknowledged
      a_r6_ack_quiet: assert property (@(posedge clk) disable iff (rst)
        gate_ack |-> !dn_busy);
    end else begin : g_nogate
      logic unused_in;
      assign unused_in = gate_req ^ gate_err_sel ^ idle ^ dn_busy ^ clk ^ rst;
      assign gate_on   = 1'b0;
      assign stall     = 1'b0;
      assign gate_ack  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/mpc_access_filter.sv
module mpc_access_filter
  import mpc_flt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CFG_W      = 4,
  parameter int unsigned LUT_WORDS  = 8,
  parameter bit [63:0]   RANGE_BASE = 64'h2000_0000,
  parameter bit          GATING_EN  = 1'b1,
  localparam int unsigned WORD_AW   = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CFG_W-1:0]   blk_cfg,
  input  logic               lut_we,
  input  logic [WORD_AW-1:0] lut_waddr,
  input  logic [31:0]        lut_wdata,
  input  logic               up_valid,
  output logic               up_ready,
  input  logic [ADDR_W-1:0]  up_addr,
  input  logic               up_write,
  input  logic               up_nonsec,
  output logic               dn_valid,
  input  logic               dn_ready,
  output logic [ADDR_W-1:0]  dn_addr,
  output logic               dn_write,
  output logic               dn_nonsec,
  output logic               resp_valid,
  output logic               resp_err,
  input  logic               fault_err_sel,
  input  logic               gate_req,
  input  logic               gate_err_sel,
  output logic               gate_ack,
  output logic               gate_present,
  input  logic               irq_en,
  input  logic               irq_clr,
  output logic               irq_stat,
  output logic               irq
);
  localparam int unsigned BIT_W      = $clog2(LUT_WORD_BITS);
  localparam int unsigned NUM_BLOCKS = LUT_WORDS * LUT_WORD_BITS;
  localparam logic [ADDR_W-1:0] BASE = RANGE_BASE[ADDR_W-1:0];

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              write;
    logic              nonsec;
    logic              in_range;
    logic [BIT_W-1:0]  bit_sel;
    logic              gated;
  } flt_cap_t;

  flt_state_e          state;
  flt_cap_t            cap;
  logic                loc_in_range;
  logic [WORD_AW-1:0]  loc_word;
  logic [BIT_W-1:0]    loc_bit;
  logic [31:0]         lut_rdata;
  logic                gate_on, stall, accept, permit, sec_fault;

  mpc_blk_locate #(
    .ADDR_W(ADDR_W), .CFG_W(CFG_W), .NUM_BLOCKS(NUM_BLOCKS),
    .WORD_AW(WORD_AW), .BIT_W(BIT_W), .BASE(BASE)
  ) u_locate (
    .addr(up_addr), .cfg(blk_cfg), .in_range(loc_in_range),
    .word_idx(loc_word), .bit_idx(loc_bit)
  );

  mpc_lut_ram #(.WORDS(LUT_WORDS), .AW(WORD_AW), .WIDTH(LUT_WORD_BITS)) u_lut (
    .clk(clk), .we(lut_we), .waddr(lut_waddr), .wdata(lut_wdata),
    .raddr(loc_word), .rdata(lut_rdata)
  );

  mpc_gate_ctl #(.GATING_EN(GATING_EN)) u_gate (
    .clk(clk), .rst(rst), .gate_req(gate_req), .gate_err_sel(gate_err_sel),
    .idle(state == FLT_IDLE), .dn_busy(dn_valid),
    .gate_on(gate_on), .stall(stall), .gate_ack(gate_ack)
  );

  assign up_ready     = (state == FLT_IDLE) && !stall;
  assign accept       = up_valid && up_ready;
  assign permit       = !cap.in_range || !cap.nonsec || lut_rdata[cap.bit_sel];
  assign sec_fault    = (state == FLT_LOOKUP) && !cap.gated && !permit;
  assign dn_addr      = cap.addr;
  assign dn_write     = cap.write;
  assign dn_nonsec    = cap.nonsec;
  assign gate_present = GATING_EN;
  assign irq          = irq_stat && irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= FLT_IDLE;
      cap        <= '0;
      dn_valid   <= 1'b0;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      irq_stat   <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        FLT_IDLE: begin
          if (accept) begin
            cap.addr     <= up_addr;
            cap.write    <= up_write;
            cap.nonsec   <= up_nonsec;
            cap.in_range <= loc_in_range;
            cap.bit_sel  <= loc_bit;
            cap.gated    <= gate_on && gate_err_sel;
            state        <= FLT_LOOKUP;
          end
        end
        FLT_LOOKUP: begin
          if (cap.gated) begin
            resp_valid <= 1'b1;
            resp_err   <= 1'b1;
            state      <= FLT_IDLE;
          end else if (permit) begin
            dn_valid   <= 1'b1;
            state      <= FLT_HOLD;
          end else begin
            resp_valid <= 1'b1;
            resp_err   <= fault_err_sel;
            state      <= FLT_IDLE;
          end
        end
        FLT_HOLD: begin
          if (dn_ready) begin
            dn_valid <= 1'b0;
            state    <= FLT_IDLE;
          end
        end
        default: state <= FLT_IDLE;
      endcase
      if (sec_fault)    irq_stat <= 1'b1;
      else if (irq_clr) irq_stat <= 1'b0;
    end
  end

  // R4: a forwarded request waiting for the downstream side stays put
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_write));
  // R2: a stopped request never also appears downstream
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(resp_valid && dn_valid));
  // R5: no acceptance while a stall is requested
  a_r5_stall: assert property (@(posedge clk) disable iff (rst)
    gate_req && !gate_err_sel && GATING_EN |-> !up_ready);
  // R8: a security stop leaves the fault status set
  a_r8_fault_sets: assert property (@(posedge clk) disable iff (rst)
    sec_fault |=> irq_stat);
  // R2: the local completion lasts a single cycle
  a_r2_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);
endmodule

// File: tb/mpc_access_filter_test.sv
module mpc_access_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic clk = 0, rst = 1;
  logic [3:0] blk_cfg = 0;
  logic lut_we = 0; logic [2:0] lut_waddr = 0; logic [31:0] lut_wdata = 0;
  logic up_valid = 0, up_write = 0, up_nonsec = 0; logic [31:0] up_addr = 0;
  logic up_ready, dn_valid, dn_write, dn_nonsec, resp_valid, resp_err;
  logic [31:0] dn_addr;
  logic dn_ready = 1, fault_err_sel = 1, gate_req = 0, gate_err_sel = 0;
  logic gate_ack, gate_present, irq_en = 0, irq_clr = 0, irq_stat, irq;

  mpc_access_filter uut (
    .clk(clk), .rst(rst), .blk_cfg(blk_cfg), .lut_we(lut_we), .lut_waddr(lut_waddr),
    .lut_wdata(lut_wdata), .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
    .up_write(up_write), .up_nonsec(up_nonsec), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_addr(dn_addr), .dn_write(dn_write), .dn_nonsec(dn_nonsec),
    .resp_valid(resp_valid), .resp_err(resp_err), .fault_err_sel(fault_err_sel),
    .gate_req(gate_req), .gate_err_sel(gate_err_sel), .gate_ack(gate_ack),
    .gate_present(gate_present), .irq_en(irq_en), .irq_clr(irq_clr),
    .irq_stat(irq_stat), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference model
  int m_state = 0;
  bit m_dnv = 0, m_dnw = 0, m_dnns = 0, m_rv = 0, m_re = 0, m_ack = 0, m_stat = 0, m_acc = 0;
  bit [31:0] m_dna = 0;
  bit c_inr = 0, c_ns = 0, c_gated = 0; int c_bit = 0; bit [31:0] c_word = 0;
  bit [31:0] m_lut [8];

  function automatic bit m_ready();
    return (m_state == 0) && !(gate_req && !gate_err_sel);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_dnv = 0; m_rv = 0; m_re = 0; m_ack = 0; m_stat = 0; m_acc = 0;
    end else begin
      bit fault, nack;
      longint unsigned offs, idx;
      fault = 0;
      nack  = gate_req && (m_state == 0);
      m_acc = up_valid && m_ready();
      m_rv  = 0;
      case (m_state)
        0: if (m_acc) begin
          offs    = longint'(up_addr - BASE);
          idx     = offs >> (blk_cfg + 5);
          c_inr   = (up_addr >= BASE) && (idx < 256);
          c_bit   = int'(idx % 32);
          c_word  = m_lut[int'((idx / 32) % 8)];
          c_ns    = up_nonsec;
          c_gated = gate_req && gate_err_sel;
          m_dna   = up_addr; m_dnw = up_write; m_dnns = up_nonsec;
          m_state = 1;
        end
        1: begin
          if (c_gated) begin m_rv = 1; m_re = 1; m_state = 0; end
          else if (!c_inr || !c_ns || c_word[c_bit]) begin m_dnv = 1; m_state = 2; end
          else begin m_rv = 1; m_re = fault_err_sel; fault = 1; m_state = 0; end
        end
        default: if (dn_ready) begin m_dnv = 0; m_state = 0; end
      endcase
      if (fault) m_stat = 1; else if (irq_clr) m_stat = 0;
      if (lut_we) m_lut[lut_waddr] = lut_wdata;
      m_ack = nack;
    end
  end

  always @(negedge clk) if (!rst && !done) begin
    cmp("R5 up_ready", up_ready, m_ready());
    cmp("R4 dn_valid", dn_valid, m_dnv);
    if (m_dnv) begin
      cmp("R4 dn_addr", dn_addr, m_dna);
      cmp("R4 dn_write", dn_write, m_dnw);
      cmp("R4 dn_nonsec", dn_nonsec, m_dnns);
    end
    cmp("R2 resp_valid", resp_valid, m_rv);
    if (m_rv) cmp("R2 resp_err", resp_err, m_re);
    cmp("R6 gate_ack", gate_ack, m_ack);
    cmp("R8 irq_stat", irq_stat, m_stat);
    cmp("R8 irq", irq, m_stat && irq_en);
    cmp("R9 gate_present", gate_present, 1);
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic lut_write(int w, logic [31:0] d);
    lut_we = 1; lut_waddr = 3'(w); lut_wdata = d; tick(); lut_we = 0;
  endtask

  task automatic wait_accept();
    for (int i = 0; i < 50; i++) begin
      tick();
      if (m_acc) break;
    end
    up_valid = 0;
  endtask

  // kind: 0 forwarded, 1 quiet completion, 2 bus error
  task automatic xfer(string tag, logic [31:0] a, bit ns, bit wr, int kind);
    bit seen;
    up_valid = 1; up_addr = a; up_nonsec = ns; up_write = wr;
    wait_accept();
    seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (dn_valid || resp_valid) begin
        seen = 1;
        cmp({tag, " fwd"}, dn_valid, kind == 0);
        if (kind != 0) cmp({tag, " err"}, resp_err, kind == 2);
      end
    end
    if (!seen) cmp({tag, " outcome"}, 0, 1);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 0;
    @(negedge clk);
    cmp("R5 reset up_ready", up_ready, 1);
    cmp("R4 reset dn_valid", dn_valid, 0);
    cmp("R8 reset irq_stat", irq_stat, 0);
    cmp("R6 reset gate_ack", gate_ack, 0);
    tick();
    for (int w = 0; w < 8; w++) lut_write(w, 32'h0);
    lut_write(0, 32'h0000_00F0);
    lut_write(1, 32'h0000_0001);
    tick();
    // R1 / R2 / R3 with 32-byte blocks
    xfer("R1 ns block5 allowed", BASE + 32'hA0, 1, 0, 0);
    xfer("R2 ns block3 bus error", BASE + 32'h60, 1, 1, 2);
    fault_err_sel = 0;
    xfer("R2 ns block3 quiet", BASE + 32'h64, 1, 1, 1);
    fault_err_sel = 1;
    xfer("R3 secure block3", BASE + 32'h60, 0, 1, 0);
    xfer("R1 block31 secure", BASE + 32'h3E0, 1, 0, 2);
    xfer("R1 block32 open", BASE + 32'h400, 1, 0, 0);
    xfer("R1 block33 secure", BASE + 32'h420, 1, 0, 2);
    xfer("R3 above window", BASE + 32'h2000, 1, 0, 0);
    xfer("R3 below window", BASE - 32'h10, 1, 1, 0);
    // R8 interrupt
    irq_en = 1; tick(); @(negedge clk);
    cmp("R8 irq raised", irq, 1);
    irq_clr = 1; tick(); irq_clr = 0; tick();
    @(negedge clk);
    cmp("R8 irq cleared", irq_stat, 0);
    // R10 table rewrite
    lut_write(0, 32'h0000_0008);
    xfer("R10 block3 now open", BASE + 32'h60, 1, 0, 0);
    xfer("R10 block5 now secure", BASE + 32'hA0, 1, 0, 2);
    // R10 same-edge write and lookup: old word is used
    up_valid = 1; up_addr = BASE + 32'h60; up_nonsec = 1;
    lut_we = 1; lut_waddr = 0; lut_wdata = 32'h0;
    wait_accept(); lut_we = 0; tick(3);
    lut_write(0, 32'h0000_0008);
    // R1 with 128-byte blocks
    blk_cfg = 2;
    xfer("R1 cfg2 block3 open", BASE + 32'h1E4, 1, 0, 0);
    xfer("R1 cfg2 block5 secure", BASE + 32'h280, 1, 0, 2);
    xfer("R1 cfg2 block255 secure", BASE + 32'h7F80, 1, 0, 2);
    xfer("R3 cfg2 above window", BASE + 32'h8000, 1, 0, 0);
    blk_cfg = 0;
    // R5 / R6 stall gating
    gate_req = 1; gate_err_sel = 0;
    up_valid = 1; up_addr = BASE + 32'h60; up_nonsec = 1;
    tick(4);
    @(negedge clk);
    cmp("R5 stalled ready", up_ready, 0);
    cmp("R6 ack while stalled", gate_ack, 1);
    tick();
    gate_req = 0;
    wait_accept();
    tick(4);
    // R7 gating error mode
    gate_req = 1; gate_err_sel = 1; irq_clr = 1; tick(); irq_clr = 0;
    xfer("R7 gated error", BASE + 32'h60, 1, 0, 2);
    @(negedge clk);
    cmp("R7 no fault from gating", irq_stat, 0);
    gate_req = 0; gate_err_sel = 0; tick(2);
    // R4 / R6 held downstream transfer delays ack
    dn_ready = 0;
    xfer("R4 held forward", BASE + 32'h60, 1, 1, 0);
    gate_req = 1; tick(3);
    @(negedge clk);
    cmp("R6 ack held off", gate_ack, 0);
    dn_ready = 1; tick(3);
    @(negedge clk);
    cmp("R6 ack after drain", gate_ack, 1);
    gate_req = 0; tick(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule